// File: doc/BRIEF.md
# Recent-Value Bus Encoder and Decoder Pair

This block reduces toggling on a wide chip-to-chip data bus. It holds a transmitting end and a receiving end, and each end keeps its own small fully associative table of words that have recently crossed the bus. The sender searches its table for every outgoing word. On a hit it drives only the slot number on the low bus lines and raises a flag line. The lines above the slot field keep their previous levels. On a miss it drives the whole word with the flag low. The receiver rebuilds the word from its own table on a hit, or takes the raw lines on a miss.

Both ends apply the same update, so the two tables always agree and no extra signalling is needed. A miss writes the new word into the slot named by a round-robin victim pointer, and that pointer then moves on by one. A hit leaves the tables and the pointers alone. After reset no slot is valid. The table depth is a parameter with a default of 128, and 256 works without change. A word is accepted through a valid/ready handshake and reappears at the receiver output with a one-cycle valid pulse, at most one word per cycle.

Top module: `vcBusLink`

## Requirements
- R1: During reset `inReady`, `busValid` and `outValid` are low. In the first cycle after reset, `inReady` is high and both valid outputs stay low.
- R2: After reset every table slot is invalid. The first transfer of any value is a miss: `busHit`=0 and `busData` equals the whole word.
- R3: A word that matches a valid slot is sent as a hit: `busHit`=1 and `busData[IDX_W-1:0]` equals the number of the slot that holds it, where IDX_W = log2(DEPTH). At most one slot can match.
- R4: On a hit transfer, `busData[DATA_W-1:IDX_W]` keeps the value it had before that transfer.
- R5: Misses fill slots 0, 1, 2, … in order and wrap to slot 0 after slot DEPTH-1. A hit does not move the victim pointer.
- R6: For every word accepted in the cycle of edge k, `outValid` is high for exactly one cycle after edge k+2 and `outData` equals that word. Words come out in the order they were accepted, including back-to-back transfers.
- R7: Whenever no transfer is on the bus, both ends hold the same valid slots with the same contents, and their victim pointers are equal.
- R8: Once a word's slot has been reused by a later miss, that word is sent as a miss again.
- R9: In a cycle with no accepted word, `busValid` goes low and `busData` and `busHit` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Sender word is offered |
| inReady | output | 1 | Sender can take a word |
| inData | input | DATA_W | Word to send |
| busValid | output | 1 | A transfer is on the bus this cycle |
| busHit | output | 1 | Flag line: 1 means the low lines carry a slot number |
| busData | output | DATA_W | Bus data lines |
| outValid | output | 1 | Rebuilt word valid (one-cycle pulse) |
| outData | output | DATA_W | Rebuilt word |

## Verification
The hardest case to reach from the ports is slot reuse. A stored value only leaves its slot after the victim pointer has gone all the way round the table, and hits do not move the pointer. The bench therefore first makes some slots repeat as hits, then sends a long run of new distinct values until the pointer wraps, and then sends old values again. It also sends back-to-back words that mix hits and misses, so the receiver updates its table while the sender is already looking up the next word.

// File: rtl/vc_pkg.sv
package vc_pkg;
  // Strobes from a control unit to its end's datapath
  typedef struct packed {
    logic wrEn;     // store the transferred word in the victim slot
    logic ptrAdv;   // move the victim pointer on
    logic sendIdx;  // transfer is encoded as a slot number
  } vcStrobe_t;
endpackage

// File: rtl/vcCtrl.sv
module vcCtrl #(
  parameter int DEPTH = 128,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                xfer,
  input  logic                hit,
  output vc_pkg::vcStrobe_t   strobe,
  output logic [IDX_W-1:0]    victimPtr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  always_comb begin
    strobe.wrEn    = xfer && !hit;
    strobe.ptrAdv  = xfer && !hit;
    strobe.sendIdx = xfer && hit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      victimPtr <= '0;
    end else if (strobe.ptrAdv) begin
      victimPtr <= (victimPtr == LAST) ? '0 : victimPtr + 1'b1;
    end
  end

  // R5
  hit_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && hit) |=> $stable(victimPtr));
endmodule

// File: rtl/vcTable.sv
module vcTable #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 128,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic [IDX_W-1:0]              wrIdx,
  input  logic [DATA_W-1:0]             wrData,
  input  logic [DATA_W-1:0]             lookupData,
  output logic                          lookupHit,
  output logic [IDX_W-1:0]              lookupIdx,
  input  logic [IDX_W-1:0]              rdIdx,
  output logic [DATA_W-1:0]             rdData,
  output logic [DEPTH-1:0]              slotValid,
  output logic [DEPTH-1:0][DATA_W-1:0]  slotData
);
  logic [DEPTH-1:0] matchVec;

  always_ff @(posedge clk) begin
    if (!rstN) slotValid <= '0;
    else if (wrEn) slotValid[wrIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wrEn) slotData[wrIdx] <= wrData;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign matchVec[g] = slotValid[g] && (slotData[g] == lookupData);
  end

  always_comb begin
    lookupIdx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (matchVec[i]) lookupIdx = lookupIdx | IDX_W'(i);
    end
  end

  assign lookupHit = |matchVec;
  assign rdData    = slotData[rdIdx];

  // R3
  single_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));
endmodule

// File: rtl/vcBusLink.sv
module vcBusLink #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  output logic              busValid,
  output logic              busHit,
  output logic [DATA_W-1:0] busData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);
  localparam int IDX_W = $clog2(DEPTH);

  logic accept;
  logic txHit;
  logic [IDX_W-1:0] txIdx, txPtr, rxPtr;
  vc_pkg::vcStrobe_t txStb, rxStb;
  logic [DATA_W-1:0] txRd, rxRd, rxLookIdle;
  logic rxLookHit;
  logic [IDX_W-1:0] rxLookIdx;
  logic [DEPTH-1:0] txValid, rxValid;
  logic [DEPTH-1:0][DATA_W-1:0] txMem, rxMem;

  always_ff @(posedge clk) begin
    if (!rstN) inReady <= 1'b0;
    else inReady <= 1'b1;
  end

  assign accept = inValid && inReady;

  // Sending end
  vcCtrl #(.DEPTH(DEPTH)) txCtrl_i (
    .clk(clk), .rstN(rstN), .xfer(accept), .hit(txHit),
    .strobe(txStb), .victimPtr(txPtr));

  vcTable #(.DATA_W(DATA_W), .DEPTH(DEPTH)) txTable_i (
    .clk(clk), .rstN(rstN), .wrEn(txStb.wrEn), .wrIdx(txPtr), .wrData(inData),
    .lookupData(inData), .lookupHit(txHit), .lookupIdx(txIdx),
    .rdIdx(txPtr), .rdData(txRd), .slotValid(txValid), .slotData(txMem));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busValid <= 1'b0;
      busHit   <= 1'b0;
      busData  <= '0;
    end else begin
      busValid <= accept;
      if (accept) begin
        busHit <= txStb.sendIdx;
        if (txStb.sendIdx) busData[IDX_W-1:0] <= txIdx;
        else busData <= inData;
      end
    end
  end

  // Receiving end
  vcCtrl #(.DEPTH(DEPTH)) rxCtrl_i (
    .clk(clk), .rstN(rstN), .xfer(busValid), .hit(busHit),
    .strobe(rxStb), .victimPtr(rxPtr));

  assign rxLookIdle = '0;

  vcTable #(.DATA_W(DATA_W), .DEPTH(DEPTH)) rxTable_i (
    .clk(clk), .rstN(rstN), .wrEn(rxStb.wrEn), .wrIdx(rxPtr), .wrData(busData),
    .lookupData(rxLookIdle), .lookupHit(rxLookHit), .lookupIdx(rxLookIdx),
    .rdIdx(busData[IDX_W-1:0]), .rdData(rxRd),
    .slotValid(rxValid), .slotData(rxMem));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= busValid;
      if (busValid) outData <= rxStb.sendIdx ? rxRd : busData;
    end
  end

  // Per-slot agreement between the two ends
  logic [DEPTH-1:0] slotDiff;
  for (genvar g = 0; g < DEPTH; g++) begin : g_diff
    assign slotDiff[g] = (txValid[g] != rxValid[g]) ||
                         (txValid[g] && (txMem[g] != rxMem[g]));
  end

  // R7
  tables_agree_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |-> (slotDiff == '0 && txPtr == rxPtr));

  // R4
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && txHit) |=> busData[DATA_W-1:IDX_W] == $past(busData[DATA_W-1:IDX_W]));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accept |=> (!busValid && $stable(busData) && $stable(busHit)));

  // R6
  out_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    busValid |=> outValid);

  // R6
  out_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |=> !outValid);

  // R2
  reset_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && txValid == '0) |-> !txHit);

  logic unusedSig;
  assign unusedSig = ^{txRd, rxLookHit, rxLookIdx, rxStb.ptrAdv, txStb.ptrAdv, txStb.wrEn};
endmodule

// File: tb/vcBusLink_tb.sv
module vcBusLink_tb_top;
  localparam int DW = 32;
  localparam int DEPTH = 128;
  localparam int IW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [DW-1:0] inData = '0;
  logic inReady, busValid, busHit, outValid;
  logic [DW-1:0] busData, outData;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int hitCount = 0;
  int expHitCount = 0;
  logic done = 1'b0;

  logic [DW-1:0] expQ[$];
  int cycQ[$];

  // bench model of the shared table
  logic [DW-1:0] mTab[DEPTH];
  logic mVal[DEPTH];
  int mPtr = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vcBusLink #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .busValid(busValid), .busHit(busHit), .busData(busData),
    .outValid(outValid), .outData(outData));

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendWord(input logic [DW-1:0] w, input string req);
    logic eHit = 1'b0;
    int eIdx = 0;
    logic [DW-1:0] prevBus;
    for (int i = 0; i < DEPTH; i++) if (mVal[i] && mTab[i] == w) begin eHit = 1'b1; eIdx = i; end
    prevBus = busData;
    inValid = 1'b1;
    inData = w;
    expQ.push_back(w);
    cycQ.push_back(cyc + 2);
    @(negedge clk);
    inValid = 1'b0;
    chk(busValid == 1'b1, {req, " busValid"}, 64'(busValid), 64'd1);
    chk(busHit == eHit, {req, " busHit"}, 64'(busHit), 64'(eHit));
    if (eHit) begin
      hitCount++;
      chk(busData[IW-1:0] == IW'(eIdx), {req, " slot number"}, 64'(busData[IW-1:0]), 64'(eIdx));
      chk(busData[DW-1:IW] == prevBus[DW-1:IW], "R4 upper lines held",
          64'(busData[DW-1:IW]), 64'(prevBus[DW-1:IW]));
    end else begin
      chk(busData == w, {req, " full word"}, 64'(busData), 64'(w));
      mTab[mPtr] = w;
      mVal[mPtr] = 1'b1;
      mPtr = (mPtr == DEPTH - 1) ? 0 : mPtr + 1;
    end
  endtask

  // monitor: compare rebuilt words with the scoreboard (R6)
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R6 unexpected output", 64'(outData), 64'd0);
      end else begin
        logic [DW-1:0] e;
        int ec;
        e = expQ.pop_front();
        ec = cycQ.pop_front();
        chk(outData == e, "R6 rebuilt word", 64'(outData), 64'(e));
        chk(cyc == ec, "R6 output cycle", 64'(cyc), 64'(ec));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] holdBus;
    logic holdHit;
    for (int i = 0; i < DEPTH; i++) begin mVal[i] = 1'b0; mTab[i] = '0; end
    repeat (3) @(negedge clk);
    chk(inReady == 1'b0 && busValid == 1'b0 && outValid == 1'b0, "R1 during reset",
        64'({inReady, busValid, outValid}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(inReady == 1'b1, "R1 ready after reset", 64'(inReady), 64'd1);
    chk(busValid == 1'b0 && outValid == 1'b0, "R1 valids low", 64'({busValid, outValid}), 64'd0);

    // R2: first sight of values is always a miss
    for (int i = 0; i < 6; i++) sendWord(32'hC0DE_0000 + 32'(i * 32'h0101_0011), "R2 first send");
    @(negedge clk);

    // R3/R4: repeats hit; upper lines held
    sendWord(32'hC0DE_0000, "R3 repeat slot0");
    sendWord(32'hC0DE_0000 + 32'(3 * 32'h0101_0011), "R3 repeat slot3");
    sendWord(32'hFFFF_FF00, "R2 new after hits");
    sendWord(32'hC0DE_0000 + 32'(5 * 32'h0101_0011), "R3 repeat slot5");
    sendWord(32'hFFFF_FF00, "R5 hit on slot6 after hits");

    // R9: idle keeps the bus lines and flag
    holdBus = busData;
    holdHit = busHit;
    repeat (2) @(negedge clk);
    chk(busValid == 1'b0, "R9 busValid idle", 64'(busValid), 64'd0);
    chk(busData == holdBus && busHit == holdHit, "R9 lines held",
        64'({busHit, busData}), 64'({holdHit, holdBus}));

    // back-to-back mix of hits and misses (R6, R7)
    for (int i = 0; i < 20; i++) begin
      if (i % 3 == 0) sendWord(32'hC0DE_0000 + 32'((i % 6) * 32'h0101_0011), "R3 mixed hit");
      else sendWord(32'h5A00_0000 + 32'(i), "R2 mixed miss");
    end

    // R5/R8: wrap the victim pointer with distinct misses
    for (int i = 0; i < DEPTH; i++) sendWord(32'h7700_0000 + 32'(i * 7), "R5 fill");
    // slot contents from before the wrap were reused: first value now misses
    begin
      logic wasHit;
      sendWord(32'hC0DE_0000, "R8 evicted value");
      wasHit = busHit;
      chk(wasHit == 1'b0, "R8 evicted value is a miss", 64'(wasHit), 64'd0);
    end
    sendWord(32'h7700_0000 + 32'(DEPTH - 1) * 32'd7, "R3 recent fill still held");
    sendWord(32'hC0DE_0000, "R3 reloaded value hits");

    repeat (6) @(negedge clk);
    chk(expQ.size() == 0, "R6 all words delivered", 64'(expQ.size()), 64'd0);
    expHitCount = 0;
    chk(hitCount > 8, "R3 hit count", 64'(hitCount), 64'd9);
    $display("hits observed=%0d", hitCount);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule